// File: doc/BRIEF.md
# Processor Debug Event Control Unit

This unit sits next to a processor core and turns the core's per-cycle event strobes into logged debug events and a debug interrupt request. The strobes it takes are: an instruction retired, a branch taken, an interrupt taken (with a flag marking it critical), a trap, a set of instruction-address match strobes, and a set of data-address match strobes, each tagged as a load or a store. Address comparison, the pipeline and interrupt vectoring are done elsewhere. This unit only qualifies the strobes, records them and raises the request.

Software reaches the unit through a plain register port with two words. The control word holds an internal-debug-mode bit, a self-clearing reset-request field, one enable bit per simple event, and a 2-bit access-type mode for each data match. The status word holds one sticky bit per event, and software clears it by writing ones. A `debug_en` input, which mirrors the core's machine-state debug enable, gates instruction and branch events and the interrupt request. There is no streaming data path, so every pin is a plain control or status signal. Reads are combinational. Writes take effect at the clock edge where `reg_we` is high.

Top module: `dbg_event_ctl`

## Requirements
- R1: While and after synchronous reset (`rst` high), both words read 0, `dbg_irq` is 0 and `core_reset_req` is 0.
- R2: The control bits are: bit 3 enables instruction-retired, bit 4 taken-branch, bit 5 interrupt-taken, bit 6 trap, and bits 7 and up enable the instruction-address matches (bit 7+i for match i). A strobe whose enable bit is 0 never sets its status bit.
- R3: Data match j has a 2-bit mode at control bits [10+2j:9+2j] (bits [10:9] and [12:11] by default). Mode 00 means never, 01 means store-tagged strobes only, 10 means load-tagged strobes only, and 11 means any access. A match strobe that the mode accepts sets the status bit for that match.
- R4: When control bit 0 (internal debug mode) is 0, no status bit is set and `dbg_irq` stays 0.
- R5: Instruction-retired and taken-branch strobes set nothing while `debug_en` is 0, even with their enables at 1. The other events are still logged.
- R6: An interrupt-taken strobe with the critical flag high is never logged. With the flag low and the enable set, it sets the status bit.
- R7: `dbg_irq` is a level. It is high exactly while internal debug mode is 1, `debug_en` is 1 and any status bit is set. It follows the status register from the cycle after the event. A bit left set from earlier asserts it again when `debug_en` returns to 1.
- R8: Status bits are sticky. They clear only when software writes 1 to them at status address 1. Writing 0 leaves a bit unchanged.
- R9: If a strobe sets a status bit in the same cycle that software clears it, the bit stays set.
- R10: A control write with bit 2 (the upper bit of the reset field [2:1]) set makes `core_reset_req` high for the single following cycle, and only if `debug_en` and the written internal-debug-mode bit are both 1. The field then reads 0 again. Field values 00 and 01 request nothing.
- R11: Control bits above the last data-mode field (bit 13 and up by default) read 0 whatever was written. Status bits above the last event read 0.
- R12: Address 0 is the control word and address 1 the status word. Status bits are: 0 instruction-retired, 1 taken-branch, 2 interrupt-taken, 3 trap, 4+i instruction match i, then 4+NUM_IAC+j data match j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| debug_en | input | 1 | Core machine-state debug enable |
| ev_icmp | input | 1 | Instruction retired this cycle |
| ev_brt | input | 1 | Branch taken this cycle |
| ev_irq | input | 1 | Interrupt taken this cycle |
| ev_irq_crit | input | 1 | The interrupt taken is critical |
| ev_trap | input | 1 | Trap this cycle |
| ev_iac | input | NUM_IAC | Instruction-address match strobes |
| ev_dac_hit | input | NUM_DAC | Data-address match strobes |
| ev_dac_store | input | NUM_DAC | Per match: 1 = store access, 0 = load access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| dbg_irq | output | 1 | Debug interrupt request (level) |
| core_reset_req | output | 1 | Core-only hard reset request pulse |

## Verification
The bench builds the unit with its defaults: DATA_W=32, NUM_IAC=2 and NUM_DAC=2. With these, both instruction matches and both data matches exist, so all four data-mode encodings can be tried on each match, with store and load tags. The full 13-bit control layout also exists at these values, which makes the reserved bits 13 to 31 reachable through an all-ones write. The bench also covers the case where a set and a clear of the same status bit land in one cycle, and the case where `debug_en` toggles while a status bit is left set, which exercises the redundant-interrupt behaviour.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  // control word bit positions
  localparam int CTL_IDM    = 0;
  localparam int CTL_RST_LO = 1;
  localparam int CTL_RST_HI = 2;
  localparam int CTL_ICMP   = 3;
  localparam int CTL_BRT    = 4;
  localparam int CTL_IRPT   = 5;
  localparam int CTL_TRAP   = 6;
  localparam int CTL_IAC0   = 7;

  // status word bit positions
  localparam int ST_ICMP = 0;
  localparam int ST_BRT  = 1;
  localparam int ST_IRPT = 2;
  localparam int ST_TRAP = 3;
  localparam int ST_IAC0 = 4;

  typedef enum logic [1:0] {
    DAC_OFF   = 2'b00,
    DAC_STORE = 2'b01,
    DAC_LOAD  = 2'b10,
    DAC_ANY   = 2'b11
  } dac_mode_e;

  function automatic logic dac_accept(dac_mode_e mode, logic hit, logic is_store);
    logic ok;
    unique case (mode)
      DAC_OFF:   ok = 1'b0;
      DAC_STORE: ok = is_store;
      DAC_LOAD:  ok = !is_store;
      default:   ok = 1'b1;
    endcase
    return hit & ok;
  endfunction
endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_evt_pkg::*;
#(
  parameter int CTL_USED = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CTL_USED-1:0] wdata,
  input  logic                debug_en,
  output logic [CTL_USED-1:0] ctl_q,
  output logic                reset_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= wdata;
    end else begin
      // reset request field lives for one cycle only
      ctl_q[CTL_RST_HI:CTL_RST_LO] <= 2'b00;
    end
  end

  assign reset_req = ctl_q[CTL_RST_HI] & ctl_q[CTL_IDM] & debug_en;
endmodule

// File: rtl/dbg_event_qual.sv
module dbg_event_qual
  import dbg_evt_pkg::*;
#(
  parameter int NUM_IAC  = 2,
  parameter int NUM_DAC  = 2,
  parameter int CTL_USED = 13,
  parameter int NUM_EV   = 8
) (
  input  logic [CTL_USED-1:0] ctl,
  input  logic                debug_en,
  input  logic                ev_icmp,
  input  logic                ev_brt,
  input  logic                ev_irq,
  input  logic                ev_irq_crit,
  input  logic                ev_trap,
  input  logic [NUM_IAC-1:0]  ev_iac,
  input  logic [NUM_DAC-1:0]  ev_dac_hit,
  input  logic [NUM_DAC-1:0]  ev_dac_store,
  output logic [NUM_EV-1:0]   ev_vec
);
  localparam int CTL_DAC0 = CTL_IAC0 + NUM_IAC;
  localparam int ST_DAC0  = ST_IAC0 + NUM_IAC;

  assign ev_vec[ST_ICMP] = ctl[CTL_ICMP] & debug_en & ev_icmp;
  assign ev_vec[ST_BRT]  = ctl[CTL_BRT] & debug_en & ev_brt;
  assign ev_vec[ST_IRPT] = ctl[CTL_IRPT] & ev_irq & !ev_irq_crit;
  assign ev_vec[ST_TRAP] = ctl[CTL_TRAP] & ev_trap;

  for (genvar i = 0; i < NUM_IAC; i++) begin : g_iac
    assign ev_vec[ST_IAC0+i] = ctl[CTL_IAC0+i] & ev_iac[i];
  end

  for (genvar j = 0; j < NUM_DAC; j++) begin : g_dac
    dac_mode_e mode;
    assign mode = dac_mode_e'(ctl[CTL_DAC0+2*j +: 2]);
    assign ev_vec[ST_DAC0+j] = dac_accept(mode, ev_dac_hit[j], ev_dac_store[j]);
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
  parameter int NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_en,
  input  logic [NUM_EV-1:0] ev_vec,
  input  logic              clr_en,
  input  logic [NUM_EV-1:0] clr_mask,
  output logic [NUM_EV-1:0] status_q
);
  logic [NUM_EV-1:0] keep, setv;

  always_comb begin
    keep = clr_en ? (status_q & ~clr_mask) : status_q;
    setv = log_en ? ev_vec : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= keep | setv;
  end
endmodule

// File: rtl/dbg_event_ctl.sv
module dbg_event_ctl
  import dbg_evt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_IAC = 2,
  parameter int NUM_DAC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               debug_en,
  input  logic               ev_icmp,
  input  logic               ev_brt,
  input  logic               ev_irq,
  input  logic               ev_irq_crit,
  input  logic               ev_trap,
  input  logic [NUM_IAC-1:0] ev_iac,
  input  logic [NUM_DAC-1:0] ev_dac_hit,
  input  logic [NUM_DAC-1:0] ev_dac_store,
  input  logic               reg_we,
  input  logic               reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               dbg_irq,
  output logic               core_reset_req
);
  localparam int CTL_USED = CTL_IAC0 + NUM_IAC + 2 * NUM_DAC;
  localparam int NUM_EV   = ST_IAC0 + NUM_IAC + NUM_DAC;

  logic [CTL_USED-1:0] ctl_q;
  logic [NUM_EV-1:0]   ev_vec;
  logic [NUM_EV-1:0]   status_q;
  logic                idm;
  logic                ctl_wr, st_wr;
  logic                unused_wbits;

  assign ctl_wr       = reg_we & !reg_addr;
  assign st_wr        = reg_we & reg_addr;
  assign idm          = ctl_q[CTL_IDM];
  assign unused_wbits = ^reg_wdata;

  dbg_ctl_reg #(.CTL_USED(CTL_USED)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_wr),
    .wdata     (reg_wdata[CTL_USED-1:0]),
    .debug_en  (debug_en),
    .ctl_q     (ctl_q),
    .reset_req (core_reset_req)
  );

  dbg_event_qual #(
    .NUM_IAC (NUM_IAC),
    .NUM_DAC (NUM_DAC),
    .CTL_USED(CTL_USED),
    .NUM_EV  (NUM_EV)
  ) u_qual (
    .ctl          (ctl_q),
    .debug_en     (debug_en),
    .ev_icmp      (ev_icmp),
    .ev_brt       (ev_brt),
    .ev_irq       (ev_irq),
    .ev_irq_crit  (ev_irq_crit),
    .ev_trap      (ev_trap),
    .ev_iac       (ev_iac),
    .ev_dac_hit   (ev_dac_hit),
    .ev_dac_store (ev_dac_store),
    .ev_vec       (ev_vec)
  );

  dbg_status_reg #(.NUM_EV(NUM_EV)) u_status (
    .clk      (clk),
    .rst      (rst),
    .log_en   (idm),
    .ev_vec   (ev_vec),
    .clr_en   (st_wr),
    .clr_mask (reg_wdata[NUM_EV-1:0]),
    .status_q (status_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[NUM_EV-1:0]   = status_q;
    else          reg_rdata[CTL_USED-1:0] = ctl_q;
  end

  assign dbg_irq = idm & debug_en & (|status_q);
endmodule

// File: rtl/dbg_event_ctl_chk.sv
module dbg_event_ctl_chk #(
  parameter int NUM_EV = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              debug_en,
  input logic              reg_we,
  input logic              reg_addr,
  input logic              idm_q,
  input logic [NUM_EV-1:0] status_q,
  input logic              dbg_irq,
  input logic              core_reset_req
);
  // R4
  no_log_chk: assert property (@(posedge clk) disable iff (rst)
    !idm_q |=> ((status_q & ~$past(status_q)) == '0));

  // R5
  icmp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!debug_en && !status_q[0]) |=> !status_q[0]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr) |=> ((~status_q & $past(status_q)) == '0));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |-> (debug_en && idm_q && status_q != '0));

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (core_reset_req && !(reg_we && !reg_addr)) |=> !core_reset_req);

  // R10
  rst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    core_reset_req |-> (debug_en && idm_q));
endmodule

bind dbg_event_ctl dbg_event_ctl_chk #(.NUM_EV(NUM_EV)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .debug_en       (debug_en),
  .reg_we         (reg_we),
  .reg_addr       (reg_addr),
  .idm_q          (ctl_q[0]),
  .status_q       (status_q),
  .dbg_irq        (dbg_irq),
  .core_reset_req (core_reset_req)
);

// File: tb/sim_dbg_event_ctl.sv
module sim_dbg_event_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        debug_en = 1'b0;
  logic        ev_icmp = 1'b0, ev_brt = 1'b0, ev_irq = 1'b0, ev_irq_crit = 1'b0, ev_trap = 1'b0;
  logic [1:0]  ev_iac = '0, ev_dac_hit = '0, ev_dac_store = '0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_irq, core_reset_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_event_ctl u0 (
    .clk(clk), .rst(rst), .debug_en(debug_en),
    .ev_icmp(ev_icmp), .ev_brt(ev_brt), .ev_irq(ev_irq), .ev_irq_crit(ev_irq_crit),
    .ev_trap(ev_trap), .ev_iac(ev_iac), .ev_dac_hit(ev_dac_hit), .ev_dac_store(ev_dac_store),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dbg_irq(dbg_irq), .core_reset_req(core_reset_req)
  );

  // control: {dac2[12:11], dac1[10:9], en[8:3] = {iac2,iac1,trap,irpt,brt,icmp}, rst[2:1]=0, idm[0]}
  function automatic logic [12:0] mk_ctl(logic idm, logic [5:0] en, logic [1:0] d1, logic [1:0] d2);
    return {d2, d1, en, 2'b00, idm};
  endfunction

  // vector: {ctl[32:20], de[19], ev[18:8], exp[7:0]}
  // ev bits: 0 icmp,1 brt,2 irq,3 crit,4 trap,5 iac1,6 iac2,7 d1hit,8 d1st,9 d2hit,10 d2st
  function automatic logic [32:0] mk_vec(logic [12:0] c, logic de, logic [10:0] e, logic [7:0] x);
    return {c, de, e, x};
  endfunction

  localparam logic [12:0] ALL = 13'h1FF9;
  localparam int NV = 17;
  localparam logic [32:0] VECS [NV] = '{
    mk_vec(ALL, 1'b1, 11'h013, 8'h0B),
    mk_vec(ALL, 1'b0, 11'h013, 8'h08),
    mk_vec(mk_ctl(1'b0, 6'h3F, 2'b11, 2'b11), 1'b1, 11'h2F7, 8'h00),
    mk_vec(mk_ctl(1'b1, 6'h3E, 2'b11, 2'b11), 1'b1, 11'h003, 8'h02),
    mk_vec(ALL, 1'b1, 11'h00C, 8'h00),
    mk_vec(ALL, 1'b1, 11'h004, 8'h04),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b01, 2'b00), 1'b1, 11'h180, 8'h40),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b01, 2'b00), 1'b1, 11'h080, 8'h00),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b10, 2'b00), 1'b1, 11'h080, 8'h40),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b10, 2'b00), 1'b1, 11'h180, 8'h00),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b00, 2'b00), 1'b1, 11'h180, 8'h00),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b00, 2'b11), 1'b1, 11'h200, 8'h80),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b00, 2'b11), 1'b1, 11'h600, 8'h80),
    mk_vec(mk_ctl(1'b1, 6'h1F, 2'b11, 2'b11), 1'b1, 11'h060, 8'h10),
    mk_vec(mk_ctl(1'b1, 6'h37, 2'b11, 2'b11), 1'b1, 11'h010, 8'h00),
    mk_vec(ALL, 1'b1, 11'h3F7, 8'hFF),
    mk_vec(mk_ctl(1'b1, 6'h3F, 2'b00, 2'b00), 1'b1, 11'h040, 8'h20)
  };

  function automatic string tag_of(int i);
    case (i)
      1:               return "R5";
      2:               return "R4";
      3, 13, 14, 16:   return "R2";
      4, 5:            return "R6";
      0, 15:           return "R12";
      default:         return "R3";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive_ev(logic [10:0] e);
    ev_icmp = e[0]; ev_brt = e[1]; ev_irq = e[2]; ev_irq_crit = e[3]; ev_trap = e[4];
    ev_iac = {e[6], e[5]}; ev_dac_hit = {e[9], e[7]}; ev_dac_store = {e[10], e[8]};
  endtask

  task automatic pulse(logic [10:0] e);
    @(negedge clk);
    drive_ev(e);
    @(posedge clk); #1;
    drive_ev('0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    rd(1'b0, r); chk("R1", "ctl in reset", r, 32'h0);
    rd(1'b1, r); chk("R1", "status in reset", r, 32'h0);
    chk("R1", "irq in reset", {31'b0, dbg_irq}, 32'h0);
    chk("R1", "reset req in reset", {31'b0, core_reset_req}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    rd(1'b0, r); chk("R1", "ctl after reset", r, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [12:0] c;
      logic [10:0] e;
      logic [7:0]  x;
      logic        de;
      {c, de, e, x} = VECS[i];
      debug_en = de;
      wr(1'b0, {19'b0, c});
      wr(1'b1, 32'hFF);
      pulse(e);
      rd(1'b1, r);
      chk(tag_of(i), $sformatf("status vec %0d", i), r, {24'b0, x});
      chk("R7", $sformatf("irq vec %0d", i), {31'b0, dbg_irq},
          {31'b0, c[0] & de & (x != 8'h00)});
    end

    // R11 reserved bits
    debug_en = 1'b1;
    wr(1'b0, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    rd(1'b0, r); chk("R11", "ctl reserved", r, 32'h0000_1FF9);
    rd(1'b1, r); chk("R11", "status upper bits", r & 32'hFFFF_FF00, 32'h0);

    // R8 write-one-to-clear, writing 0 keeps
    wr(1'b1, 32'hFF);
    pulse(11'h011);
    wr(1'b1, 32'h0);
    rd(1'b1, r); chk("R8", "write zero keeps", r, 32'h09);
    wr(1'b1, 32'h01);
    rd(1'b1, r); chk("R8", "clear one bit", r, 32'h08);

    // R9 set beats clear in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h08; ev_trap = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0; ev_trap = 1'b0;
    rd(1'b1, r); chk("R9", "set wins over clear", r, 32'h08);

    // R7 level and redundant interrupt
    chk("R7", "irq with status", {31'b0, dbg_irq}, 32'h1);
    debug_en = 1'b0; #1;
    chk("R7", "irq debug_en low", {31'b0, dbg_irq}, 32'h0);
    repeat (2) @(posedge clk); #1;
    debug_en = 1'b1; #1;
    chk("R7", "redundant irq", {31'b0, dbg_irq}, 32'h1);
    wr(1'b0, 32'h0000_1FF8);
    rd(1'b1, r); chk("R4", "status kept, idm off", r, 32'h08);
    chk("R4", "irq with idm off", {31'b0, dbg_irq}, 32'h0);
    wr(1'b1, 32'hFF);

    // R10 reset request
    wr(1'b0, 32'h5);
    chk("R10", "reset req pulse", {31'b0, core_reset_req}, 32'h1);
    @(posedge clk); #1;
    chk("R10", "reset req cleared", {31'b0, core_reset_req}, 32'h0);
    rd(1'b0, r); chk("R10", "field self clear", r, 32'h1);
    wr(1'b0, 32'h3);
    chk("R10", "low bit only", {31'b0, core_reset_req}, 32'h0);
    wr(1'b0, 32'h1);
    chk("R10", "field 00", {31'b0, core_reset_req}, 32'h0);
    debug_en = 1'b0;
    wr(1'b0, 32'h5);
    chk("R10", "debug_en low", {31'b0, core_reset_req}, 32'h0);
    debug_en = 1'b1;
    wr(1'b0, 32'h4);
    chk("R10", "idm low", {31'b0, core_reset_req}, 32'h0);

    // R1 reset again clears all
    wr(1'b0, 32'h1FF9);
    pulse(11'h010);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    rd(1'b1, r); chk("R1", "status after reset", r, 32'h0);
    rd(1'b0, r); chk("R1", "ctl after reset", r, 32'h0);
    @(negedge clk); rst = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule